// File: doc/BRIEF.md
# DMA Channel Bus Arbiter with Read/Write Pairing

This block decides which DMA channel drives the next bus transfer. It also sequences each transfer as an indivisible read cycle followed by a write cycle. There are two configurations. With `full_mode` low, four sub-channels compete. With `full_mode` high, the sub-channel request lines fold pairwise into two wide channels. Every channel supplies a request line, a 2-bit transfer kind and a last-pair flag. The arbiter returns a registered one-hot grant, a bus-cycle code and a request-clear strobe.

Three other bus users share the bus: memory refresh, external bus hand-over and an auxiliary transfer engine. The arbiter admits them only at points where no read/write pair is open. A channel that is running a burst, or is inside a block, keeps the bus across such an interruption and resumes without a new arbitration. New arbitration happens only when the bus comes back to idle.

Top module: `dma_prio_arb`

## Requirements
- R1: With `full_mode` low, a new grant goes to the lowest-numbered requesting sub-channel (bit 0 = 0A, bit 1 = 0B, bit 2 = 1A, bit 3 = 1B, bit 0 highest), sampled in the idle cycle in which the bus is taken.
- R2: With `full_mode` high, channel 0 requests when `ch_req[0]` or `ch_req[1]` is high and is granted on `ch_gnt[0]`. Channel 1 requests from `ch_req[2]` or `ch_req[3]` and is granted on `ch_gnt[2]`. Channel 0 wins ties. Each channel takes its kind and last flag from slot 0 or slot 2 respectively.
- R3: `bus_cyc` is 00 idle, 01 read, 10 write. Every read is followed directly by a write carrying the same grant. `ch_gnt` is one-hot during read and write and zero whenever `bus_cyc` is idle.
- R4: For kind 00 (single), each pair ends its transfer. `ch_req_clr` equals the grant during that write, and the bus returns to idle for a new arbitration.
- R5: For kind 01 (burst), the granted channel keeps the bus pair after pair until a write with its last flag high. That write raises `ch_req_clr`. Higher-priority requests and withdrawal of its own request are ignored meanwhile.
- R6: For kind 10 (block), the channel is held until a write with its last flag high. That write returns the bus to idle without `ch_req_clr`, so a higher-priority request can win between blocks.
- R7: `oth_gnt` is nonzero only while `bus_cyc` is idle and `ch_gnt` is zero. It is never nonzero between a read and its write.
- R8: If another user requests during a non-final write of a burst or block, the bus passes to that user after the write. Once released, the same DMA channel resumes with no new arbitration, even if a higher-priority channel is requesting.
- R9: `oth_gnt` is one-hot with priority refresh (bit 0) over bus hand-over (bit 1) over auxiliary engine (bit 2). It is held while the granted request stays high and clears on the first edge at which that request is low.
- R10: A request that is raised and then withdrawn before it can be selected is never granted.
- R11: During and after reset, `bus_cyc`, `ch_gnt`, `ch_req_clr` and `oth_gnt` are all zero.
- R12: In an idle cycle with no locked channel, a pending other-user request is served before any pending DMA request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_mode | input | 1 | 1 = two folded channels, 0 = four sub-channels |
| ch_req | input | NSUB | Per-sub-channel transfer request |
| ch_type | input | NSUB*2 | Per-slot transfer kind: 00 single, 01 burst, 10 block |
| ch_last | input | NSUB | Per-slot flag: the current pair is the final one of the burst or block |
| oth_req | input | NOTH | Requests from refresh, bus hand-over, auxiliary engine |
| ch_gnt | output | NSUB | One-hot registered DMA grant |
| ch_req_clr | output | NSUB | Strobe during the final write that clears the owner's request |
| bus_cyc | output | 2 | Bus cycle code: 00 idle, 01 read, 10 write |
| oth_gnt | output | NOTH | One-hot grant to the other bus users |

## Verification
Priority is tried with several simultaneous request sets in both configurations. This separates a correct fixed order from a round-robin or highest-index pick, and shows that folded requests land on the even grant bits. Burst and block runs get higher-priority requests that are raised mid-run, plus one that is raised and withdrawn. These show locking versus per-pair re-arbitration, and show that block ends differ from burst ends only in the missing clear strobe. Other-user requests raised during a locked run, and together with a fresh DMA request from idle, show where the bus may be handed over and that the locked owner resumes.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'b00,
    CYC_RD   = 2'b01,
    CYC_WR   = 2'b10
  } bus_cyc_e;

  typedef enum logic [1:0] {
    XF_SINGLE = 2'b00,
    XF_BURST  = 2'b01,
    XF_BLOCK  = 2'b10
  } xfer_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RD,
    SQ_WR,
    SQ_OTH
  } seq_st_e;

  localparam int unsigned XF_W = $bits(xfer_e);

  // A kind that keeps the bus beyond a single pair
  function automatic logic kind_locks(input xfer_e k);
    return k != XF_SINGLE;
  endfunction

  // A kind whose final pair clears the owner's request
  function automatic logic kind_clears(input xfer_e k);
    return k != XF_BLOCK;
  endfunction

  function automatic bus_cyc_e cyc_of(input seq_st_e s);
    case (s)
      SQ_RD:   return CYC_RD;
      SQ_WR:   return CYC_WR;
      default: return CYC_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] oh,
  output logic         any
);
  // bit 0 is the highest priority
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_top
      assign oh[i] = req[i];
    end else begin : g_rest
      assign oh[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign any = |req;
endmodule

// File: rtl/dma_arb_req_map.sv
module dma_arb_req_map
  import dma_arb_pkg::*;
#(
  parameter int unsigned NSUB = 4
) (
  input  logic                 full_mode,
  input  logic [NSUB-1:0]      req,
  input  logic [NSUB-1:0]      last,
  input  logic [NSUB*XF_W-1:0] kind,
  output logic [NSUB-1:0]      eff_req,
  output logic [NSUB-1:0]      eff_last,
  output logic [NSUB*XF_W-1:0] eff_kind
);
  localparam int unsigned NPAIR = NSUB / 2;

  // In folded mode the even slot of every pair stands for the whole channel
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int unsigned EV = 2 * p;
    localparam int unsigned OD = 2 * p + 1;

    assign eff_req[EV]  = full_mode ? (req[EV] | req[OD]) : req[EV];
    assign eff_req[OD]  = full_mode ? 1'b0 : req[OD];
    assign eff_last[EV] = last[EV];
    assign eff_last[OD] = full_mode ? 1'b0 : last[OD];
    assign eff_kind[EV*XF_W +: XF_W] = kind[EV*XF_W +: XF_W];
    assign eff_kind[OD*XF_W +: XF_W] = full_mode ? XF_W'(0) : kind[OD*XF_W +: XF_W];
  end
endmodule

// File: rtl/dma_arb_ext_gate.sv
module dma_arb_ext_gate #(
  parameter int unsigned NOTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [NOTH-1:0] oth_req,
  output logic [NOTH-1:0] oth_gnt,
  output logic            oth_any,
  output logic            oth_held
);
  logic [NOTH-1:0] pick_oh;
  logic [NOTH-1:0] gnt_q;

  dma_arb_pick #(.N(NOTH)) u_pick (
    .req (oth_req),
    .oh  (pick_oh),
    .any (oth_any)
  );

  assign oth_held = |(gnt_q & oth_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= '0;
    end else if (take) begin
      gnt_q <= pick_oh;
    end else if (!oth_held) begin
      gnt_q <= '0;
    end
  end

  assign oth_gnt = gnt_q;
endmodule

// File: rtl/dma_arb_seq.sv
module dma_arb_seq
  import dma_arb_pkg::*;
#(
  parameter int unsigned NSUB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSUB-1:0]      pick_oh,
  input  logic                 pick_any,
  input  logic [NSUB*XF_W-1:0] eff_kind,
  input  logic [NSUB-1:0]      eff_last,
  input  logic                 oth_any,
  input  logic                 oth_held,
  output logic                 take_oth,
  output logic [NSUB-1:0]      gnt,
  output logic [NSUB-1:0]      req_clr,
  output logic [1:0]           cyc,
  output logic                 ev_grant_new,
  output logic                 ev_resume,
  output logic                 ev_release
);
  seq_st_e         st_q, st_n;
  logic [NSUB-1:0] gnt_q, gnt_n;
  logic [NSUB-1:0] own_q, own_n;
  logic            lock_q, lock_n;
  xfer_e           kind_q, kind_n;
  xfer_e           pick_kind;
  logic            cur_last;
  logic            pair_final;

  always_comb begin
    pick_kind = XF_SINGLE;
    for (int i = 0; i < NSUB; i++) begin
      if (pick_oh[i]) pick_kind = xfer_e'(eff_kind[i*XF_W +: XF_W]);
    end
  end

  assign cur_last   = |(eff_last & gnt_q);
  assign pair_final = !kind_locks(kind_q) || cur_last;

  always_comb begin
    st_n     = st_q;
    gnt_n    = gnt_q;
    own_n    = own_q;
    lock_n   = lock_q;
    kind_n   = kind_q;
    take_oth = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (lock_q) begin
          st_n  = SQ_RD;
          gnt_n = own_q;
        end else if (oth_any) begin
          st_n     = SQ_OTH;
          take_oth = 1'b1;
        end else if (pick_any) begin
          st_n   = SQ_RD;
          gnt_n  = pick_oh;
          own_n  = pick_oh;
          kind_n = pick_kind;
        end
      end
      SQ_RD: st_n = SQ_WR;
      SQ_WR: begin
        if (pair_final) begin
          st_n   = SQ_IDLE;
          gnt_n  = '0;
          lock_n = 1'b0;
        end else begin
          lock_n = 1'b1;
          if (oth_any) begin
            st_n     = SQ_OTH;
            take_oth = 1'b1;
            gnt_n    = '0;
          end else begin
            st_n = SQ_RD;
          end
        end
      end
      SQ_OTH: if (!oth_held) st_n = SQ_IDLE;
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      gnt_q  <= '0;
      own_q  <= '0;
      lock_q <= 1'b0;
      kind_q <= XF_SINGLE;
    end else begin
      st_q   <= st_n;
      gnt_q  <= gnt_n;
      own_q  <= own_n;
      lock_q <= lock_n;
      kind_q <= kind_n;
    end
  end

  assign gnt     = gnt_q;
  assign cyc     = cyc_of(st_q);
  assign req_clr = (st_q == SQ_WR && pair_final && kind_clears(kind_q)) ? gnt_q : '0;

  assign ev_grant_new = (st_q == SQ_IDLE) && !lock_q && !oth_any && pick_any;
  assign ev_resume    = (st_q == SQ_IDLE) && lock_q;
  assign ev_release   = (st_q == SQ_WR) && pair_final;
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned NSUB = 4,
  parameter int unsigned NOTH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 full_mode,
  input  logic [NSUB-1:0]      ch_req,
  input  logic [NSUB*XF_W-1:0] ch_type,
  input  logic [NSUB-1:0]      ch_last,
  input  logic [NOTH-1:0]      oth_req,
  output logic [NSUB-1:0]      ch_gnt,
  output logic [NSUB-1:0]      ch_req_clr,
  output logic [1:0]           bus_cyc,
  output logic [NOTH-1:0]      oth_gnt
);
  logic [NSUB-1:0]      eff_req;
  logic [NSUB-1:0]      eff_last;
  logic [NSUB*XF_W-1:0] eff_kind;
  logic [NSUB-1:0]      pick_oh;
  logic                 pick_any;
  logic                 take_oth;
  logic                 oth_any;
  logic                 oth_held;
  logic                 ev_grant_new;
  logic                 ev_resume;
  logic                 ev_release;

  dma_arb_req_map #(.NSUB(NSUB)) u_map (
    .full_mode (full_mode),
    .req       (ch_req),
    .last      (ch_last),
    .kind      (ch_type),
    .eff_req   (eff_req),
    .eff_last  (eff_last),
    .eff_kind  (eff_kind)
  );

  dma_arb_pick #(.N(NSUB)) u_pick (
    .req (eff_req),
    .oh  (pick_oh),
    .any (pick_any)
  );

  dma_arb_ext_gate #(.NOTH(NOTH)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take_oth),
    .oth_req  (oth_req),
    .oth_gnt  (oth_gnt),
    .oth_any  (oth_any),
    .oth_held (oth_held)
  );

  dma_arb_seq #(.NSUB(NSUB)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pick_oh      (pick_oh),
    .pick_any     (pick_any),
    .eff_kind     (eff_kind),
    .eff_last     (eff_last),
    .oth_any      (oth_any),
    .oth_held     (oth_held),
    .take_oth     (take_oth),
    .gnt          (ch_gnt),
    .req_clr      (ch_req_clr),
    .cyc          (bus_cyc),
    .ev_grant_new (ev_grant_new),
    .ev_resume    (ev_resume),
    .ev_release   (ev_release)
  );
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int unsigned NSUB = 4,
  parameter int unsigned NOTH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            full_mode,
  input logic [NSUB-1:0] ch_req,
  input logic [NSUB-1:0] ch_gnt,
  input logic [NSUB-1:0] ch_req_clr,
  input logic [1:0]      bus_cyc,
  input logic [NOTH-1:0] oth_gnt,
  input logic            ev_grant_new,
  input logic            ev_release
);
  function automatic logic [NSUB-1:0] odd_bits();
    logic [NSUB-1:0] m;
    m = '0;
    for (int i = 1; i < NSUB; i += 2) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [NSUB-1:0] ODD_MASK = odd_bits();

  p_prio_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_grant_new && !full_mode) |=>
      ((ch_gnt & $past(ch_req)) != '0) && (($past(ch_req) & (ch_gnt - NSUB'(1))) == '0));

  p_full_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_mode && bus_cyc != 2'b00 && $past(full_mode)) |-> ((ch_gnt & ODD_MASK) == '0));

  p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc == 2'b01) |=> (bus_cyc == 2'b10) && (ch_gnt == $past(ch_gnt)));

  p_gnt_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc != 2'b00) |-> ($countones(ch_gnt) == 1));

  p_gnt_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc == 2'b00) |-> (ch_gnt == '0));

  p_clr_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req_clr != '0) |-> (bus_cyc == 2'b10) && (ch_req_clr == ch_gnt));

  p_release_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> (bus_cyc == 2'b00));

  p_oth_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oth_gnt != '0) |-> (bus_cyc == 2'b00) && (ch_gnt == '0));

  p_oth_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oth_gnt));
endmodule

bind dma_prio_arb dma_arb_chk #(.NSUB(NSUB), .NOTH(NOTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .full_mode    (full_mode),
  .ch_req       (ch_req),
  .ch_gnt       (ch_gnt),
  .ch_req_clr   (ch_req_clr),
  .bus_cyc      (bus_cyc),
  .oth_gnt      (oth_gnt),
  .ev_grant_new (ev_grant_new),
  .ev_release   (ev_release)
);

// File: tb/tb_dma_prio_arb.sv
module tb_dma_prio_arb;
  import dma_arb_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       full_mode;
  logic [3:0] ch_req;
  logic [3:0] ch_last;
  logic [7:0] ch_type;
  logic [2:0] oth_req;
  wire  [3:0] ch_gnt;
  wire  [3:0] ch_req_clr;
  wire  [1:0] bus_cyc;
  wire  [2:0] oth_gnt;

  dma_prio_arb dut (
    .clk(clk), .rst_n(rst_n), .full_mode(full_mode), .ch_req(ch_req),
    .ch_type(ch_type), .ch_last(ch_last), .oth_req(oth_req),
    .ch_gnt(ch_gnt), .ch_req_clr(ch_req_clr), .bus_cyc(bus_cyc), .oth_gnt(oth_gnt)
  );

  // bench-side channel devices
  int         left [4];
  int         blen [4];
  int         nblk [4];
  int         ocnt [3];
  logic [1:0] kind [4];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      ch_last[k]         = (left[k] == 1);
      ch_type[k*2 +: 2]  = kind[k];
    end
  end

  logic [1:0] s_cyc;
  logic [3:0] s_gnt, s_clr;
  logic [2:0] s_oth, p_oth;

  logic [9:0] exp_q  [$];
  string      etag_q [$];
  logic [2:0] oexp_q [$];

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    s_cyc = bus_cyc;
    s_gnt = ch_gnt;
    s_clr = ch_req_clr;
    s_oth = oth_gnt;
    if (rst_n) begin
      if (s_cyc != 2'b00) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected DMA cycle", {s_cyc, s_gnt, s_clr}, 0);
        end else begin
          logic [9:0] e;
          string      t;
          e = exp_q.pop_front();
          t = etag_q.pop_front();
          check({s_cyc, s_gnt, s_clr} == e, t, {s_cyc, s_gnt, s_clr}, e);
        end
      end
      if (s_oth != 3'b000 && p_oth == 3'b000) begin
        check(s_cyc == 2'b00 && s_gnt == 4'b0, "R7 other user during DMA", {s_cyc, s_gnt}, 0);
        if (oexp_q.size() == 0) begin
          check(1'b0, "R9 unexpected other grant", s_oth, 0);
        end else begin
          logic [2:0] oe;
          oe = oexp_q.pop_front();
          check(s_oth == oe, "R9 other-user grant order", s_oth, oe);
        end
      end
    end
    p_oth = s_oth;
  end

  // read item, then write item carrying the clear strobe
  task automatic exp_pair(input logic [3:0] g, input logic [3:0] clr, input string tag);
    exp_q.push_back({2'b01, g, 4'b0000});
    etag_q.push_back({tag, " read"});
    exp_q.push_back({2'b10, g, clr});
    etag_q.push_back({tag, " write"});
  endtask

  task automatic drop(input int sl);
    ch_req[sl] = 1'b0;
    if (full_mode) ch_req[sl ^ 1] = 1'b0;
  endtask

  // one clock: advance, then let the device models react to the last sample
  task automatic tick();
    @(posedge clk);
    #1;
    if (s_cyc == 2'b10) begin
      int sl;
      sl = 0;
      for (int k = 0; k < 4; k++) if (s_gnt[k]) sl = k;
      if (left[sl] > 0) begin
        left[sl]--;
        if (left[sl] == 0 && kind[sl] == XF_BLOCK) begin
          nblk[sl]--;
          if (nblk[sl] <= 0) drop(sl);
          else left[sl] = blen[sl];
        end
      end
      if (s_clr != 4'b0000) drop(sl);
    end
    for (int j = 0; j < 3; j++) begin
      if (s_oth[j]) begin
        ocnt[j]++;
        if (ocnt[j] >= 2) begin
          oth_req[j] = 1'b0;
          ocnt[j]    = 0;
        end
      end
    end
  endtask

  task automatic settle(input string tag);
    int n;
    n = 0;
    while ((exp_q.size() != 0 || oexp_q.size() != 0) && n < 400) begin
      tick();
      n++;
    end
    if (exp_q.size() != 0 || oexp_q.size() != 0) begin
      check(1'b0, tag, exp_q.size() + oexp_q.size(), 0);
      exp_q.delete();
      etag_q.delete();
      oexp_q.delete();
    end
    repeat (4) tick();
  endtask

  task automatic wait_read();
    int n;
    n = 0;
    while (s_cyc != 2'b01 && n < 50) begin
      tick();
      n++;
    end
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    full_mode = 1'b0;
    ch_req    = 4'b0000;
    oth_req   = 3'b000;
    s_cyc = 2'b00; s_gnt = 4'b0; s_clr = 4'b0; s_oth = 3'b0; p_oth = 3'b0;
    for (int k = 0; k < 4; k++) begin
      left[k] = 0; blen[k] = 0; nblk[k] = 0; kind[k] = XF_SINGLE;
    end
    for (int j = 0; j < 3; j++) ocnt[j] = 0;

    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_cyc == 2'b00, "R11 bus_cyc in reset", bus_cyc, 0);
    check(ch_gnt == 4'b0 && ch_req_clr == 4'b0, "R11 grant/clear in reset", {ch_gnt, ch_req_clr}, 0);
    check(oth_gnt == 3'b0, "R11 other grant in reset", oth_gnt, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 R4: short mode, singles, 0B 1A 1B requesting together
    exp_pair(4'b0010, 4'b0010, "R1 R4 0B first");
    exp_pair(4'b0100, 4'b0100, "R1 R4 1A second");
    exp_pair(4'b1000, 4'b1000, "R1 R4 1B third");
    ch_req = 4'b1110;
    settle("R1 queue not drained");

    // R5 R10: burst on 1B, 0A raised then withdrawn, 1A raised
    kind[3] = XF_BURST;
    left[3] = 3;
    exp_pair(4'b1000, 4'b0000, "R5 burst pair 1");
    exp_pair(4'b1000, 4'b0000, "R5 burst pair 2 ignores 0A");
    exp_pair(4'b1000, 4'b1000, "R5 burst final pair");
    exp_pair(4'b0100, 4'b0100, "R10 withdrawn 0A skipped, 1A");
    ch_req = 4'b1000;
    wait_read();
    ch_req[0] = 1'b1;
    ch_req[2] = 1'b1;
    tick();
    tick();
    ch_req[0] = 1'b0;
    settle("R5 queue not drained");

    // R6: two blocks of two pairs on 0B, 0A single wins between blocks
    kind[1] = XF_BLOCK;
    left[1] = 2;
    blen[1] = 2;
    nblk[1] = 2;
    exp_pair(4'b0010, 4'b0000, "R6 block1 pair1");
    exp_pair(4'b0010, 4'b0000, "R6 block1 end no clear");
    exp_pair(4'b0001, 4'b0001, "R6 0A between blocks");
    exp_pair(4'b0010, 4'b0000, "R6 block2 pair1");
    exp_pair(4'b0010, 4'b0000, "R6 block2 end no clear");
    ch_req = 4'b0010;
    wait_read();
    ch_req[0] = 1'b1;
    settle("R6 queue not drained");

    // R2: folded mode, requests on odd lines of both channels
    full_mode = 1'b1;
    kind[0] = XF_SINGLE;
    kind[2] = XF_SINGLE;
    exp_pair(4'b0001, 4'b0001, "R2 channel 0 on bit 0");
    exp_pair(4'b0100, 4'b0100, "R2 channel 1 on bit 2");
    ch_req = 4'b1010;
    settle("R2 queue not drained");
    check(ch_req == 4'b0000, "R2 both folded requests cleared", ch_req, 0);
    full_mode = 1'b0;
    tick();

    // R7 R8 R9: burst on 1A interrupted by refresh then auxiliary engine
    kind[2] = XF_BURST;
    left[2] = 3;
    exp_pair(4'b0100, 4'b0000, "R8 burst pair 1");
    exp_pair(4'b0100, 4'b0000, "R8 resume after refresh");
    exp_pair(4'b0100, 4'b0100, "R8 resume after aux, final");
    exp_pair(4'b0001, 4'b0001, "R8 0A after burst");
    oexp_q.push_back(3'b001);
    oexp_q.push_back(3'b100);
    ch_req = 4'b0100;
    wait_read();
    oth_req   = 3'b101;
    ch_req[0] = 1'b1;
    settle("R8 queue not drained");

    // R12: fresh DMA and bus hand-over requested together from idle
    kind[3] = XF_SINGLE;
    oexp_q.push_back(3'b010);
    exp_pair(4'b1000, 4'b1000, "R12 DMA after hand-over");
    ch_req[3]  = 1'b1;
    oth_req[1] = 1'b1;
    begin
      int n;
      n = 0;
      do begin
        tick();
        n++;
      end while (s_cyc == 2'b00 && s_oth == 3'b000 && n < 50);
    end
    check(s_cyc == 2'b00 && s_oth == 3'b010, "R12 other user served first",
          {s_cyc, s_oth}, {2'b00, 3'b010});
    settle("R12 queue not drained");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule